// File: doc/BRIEF.md
# SMBus Host Register Interface

This block is the software-visible front end of an SMBus host controller. It holds the byte-wide registers that a driver fills in before it launches a transaction. These are a status byte, a control byte, a command code, a slave address with its direction bit, two data bytes, and a 32-entry block-data buffer. The buffer is reached through one port whose index advances by one on every access.

The registers sit in a 64-byte I/O window and are accessed one byte at a time. A write to the control register with its start bit set launches a transaction. The block then emits a single-cycle start strobe to a separate protocol sequencer, and presents the protocol field, the command code, the device address, the direction and the data bytes. The sequencer reports back through a completion pulse, an error pulse and a response load of both data bytes. It reads outgoing block data through its own buffer read port. Wire-level signalling on the bus lines is left to that sequencer.

Host reads return data one cycle after the read request. Every register and the buffer index are reset by a synchronous, active-high reset.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, every register reads as 0, the buffer index is 0 and `seq_start` is low.
- R2: The command (offset 3), slave address (offset 4), data0 (offset 5) and data1 (offset 6) registers read back the last value written. `host_rdata` shows a value in the cycle after the one in which `host_rd` is high, and keeps it until the next read.
- R3: A read of any offset outside {0, 2, 3, 4, 5, 6, 7} in the window (offset 1 and offsets 8 to 63) returns 0. A write to such an offset changes no register.
- R4: A control write (offset 2) stores the byte. A control read returns only bits 4:0 of the stored byte, with bits 7:5 read as 0.
- R5: A control write accepted while idle, with bit 6 set and a protocol field (bits 4:2) of 0, 1, 2, 3 or 5, raises `seq_start` for exactly one cycle, in the cycle after the write. In that same cycle, status bit 0 (busy) becomes 1.
- R6: A control write accepted while idle, with bit 6 set and a protocol field of 4, 6 or 7, produces no strobe and sets status bit 2 (error).
- R7: While status bit 0 (busy) is set, control writes are ignored. The stored control byte is unchanged and no strobe is produced.
- R8: A `seq_done` pulse clears busy and sets status bit 1 (done). A `seq_err` pulse clears busy and sets bit 2 (error). Both flags stay set until software writes the status register.
- R9: Any write to status (offset 0) clears the whole status byte, whatever value is written, and returns the buffer index to 0. If a completion or error pulse arrives in the same cycle, its flag is set anyway.
- R10: Each write or read of the block port (offset 7) uses the entry at the current index and then advances the index by one. After entry 31 the index wraps to 0.
- R11: A read of the control register returns the buffer index to 0.
- R12: The sequencer outputs follow the registers. `seq_cmd` is the command byte, `seq_dev` is address bits 7:1, `seq_rnw` is address bit 0 (1 = read), `seq_prot` is control bits 4:2, and `seq_data0` and `seq_data1` are the data bytes. `seq_rsp_we` loads both data bytes from the response inputs.
- R13: `seq_blk_rdata` shows the buffer entry selected by `seq_blk_idx` one cycle after that index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_addr | input | ADDR_W | Byte offset in the window |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| seq_start | output | 1 | One-cycle transaction start strobe |
| seq_prot | output | 3 | Protocol field of the control register |
| seq_cmd | output | 8 | Command code |
| seq_dev | output | 7 | 7-bit device address |
| seq_rnw | output | 1 | Direction, 1 = read |
| seq_data0 | output | 8 | Data byte 0 |
| seq_data1 | output | 8 | Data byte 1 |
| seq_done | input | 1 | Successful completion pulse |
| seq_err | input | 1 | Failure pulse |
| seq_rsp_we | input | 1 | Load both data bytes from the response |
| seq_rsp_data0 | input | 8 | Response byte 0 |
| seq_rsp_data1 | input | 8 | Response byte 1 |
| seq_blk_idx | input | IDX_W | Sequencer buffer read index |
| seq_blk_rdata | output | 8 | Buffer entry at `seq_blk_idx`, one cycle later |

## Verification
The bench fills all 32 buffer entries and reads past the end. An index that fails to wrap, or wraps one entry early or late, then returns the wrong byte at entry 0. It sweeps every offset of the window, so a decoder that aliases an unmapped offset onto a register shows a non-zero read or a corrupted register. It sweeps all eight protocol codes with the start bit set. This catches a design that starts an invalid protocol, or flags a valid one as an error. It also tries control writes during busy, because a design that restarts there emits a second strobe or changes the stored control byte. Finally, it checks that a status write and a control read each return the index to 0, and that the status clear removes all flags at once.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  localparam int unsigned BYTE_W = 8;

  // Byte offsets inside the register window
  localparam int unsigned OFS_STS = 0;
  localparam int unsigned OFS_CTL = 2;
  localparam int unsigned OFS_CMD = 3;
  localparam int unsigned OFS_ADR = 4;
  localparam int unsigned OFS_D0  = 5;
  localparam int unsigned OFS_D1  = 6;
  localparam int unsigned OFS_BLK = 7;

  // Control and status bit positions
  localparam int unsigned CTL_GO_BIT = 6;
  localparam int unsigned ST_BUSY    = 0;
  localparam int unsigned ST_DONE    = 1;
  localparam int unsigned ST_ERR     = 2;

  function automatic logic prot_supported(input logic [2:0] p);
    return (p == 3'd0) || (p == 3'd1) || (p == 3'd2) || (p == 3'd3) || (p == 3'd5);
  endfunction

endpackage

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          idx_clr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_q,
  input  logic [IW-1:0] seq_idx,
  output logic [DW-1:0] seq_q
);

  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx;
  logic          acc;

  assign acc = host_wr || host_rd;

  // Storage and read registers, no reset on the array
  always_ff @(posedge clk) begin
    if (host_wr) mem[idx] <= host_wdata;
    seq_q <= mem[seq_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)          host_q <= '0;
    else if (host_rd) host_q <= mem[idx];
  end

  // Auto-incrementing index with wrap
  always_ff @(posedge clk) begin
    if (rst || idx_clr) idx <= '0;
    else if (acc)       idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    (acc && !idx_clr && idx == LAST) |=> (idx == '0)); // R10
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc && !idx_clr && idx != LAST) |=> (idx == $past(idx) + 1'b1)); // R10
  AST_IDX_CLR: assert property (@(posedge clk) disable iff (rst)
    idx_clr |=> (idx == '0)); // R9

endmodule

// File: rtl/smb_status.sv
module smb_status
  import smb_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              launch,
  input  logic              bad_prot,
  input  logic              done_i,
  input  logic              err_i,
  output logic [BYTE_W-1:0] status
);

  logic busy_q, done_q, err_q;
  logic busy_d, done_d, err_d;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    err_d  = err_q;
    if (clr) begin
      busy_d = 1'b0;
      done_d = 1'b0;
      err_d  = 1'b0;
    end
    if (launch)   busy_d = 1'b1;
    if (bad_prot) err_d  = 1'b1;
    if (done_i) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
    if (err_i) begin
      busy_d = 1'b0;
      err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy_q;
    status[ST_DONE] = done_q;
    status[ST_ERR]  = err_q;
  end

  AST_STS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr && !launch && !bad_prot && !done_i && !err_i) |=> (status == '0)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clr) |=> done_q); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr) |=> err_q); // R8
  AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    (done_i || err_i) |=> !busy_q); // R8

endmodule

// File: rtl/smb_rd_port.sv
module smb_rd_port
  import smb_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] sts,
  input  logic [BYTE_W-1:0] ctl,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [BYTE_W-1:0] adr,
  input  logic [BYTE_W-1:0] d0,
  input  logic [BYTE_W-1:0] d1,
  input  logic [BYTE_W-1:0] blk_q,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] rd_val;
  logic [BYTE_W-1:0] reg_q;
  logic              blk_sel_q;
  logic              mapped;

  always_comb begin
    rd_val = '0;
    mapped = 1'b1;
    case (addr)
      ADDR_W'(OFS_STS): rd_val = sts;
      ADDR_W'(OFS_CTL): rd_val = {3'b000, ctl[4:0]};
      ADDR_W'(OFS_CMD): rd_val = cmd;
      ADDR_W'(OFS_ADR): rd_val = adr;
      ADDR_W'(OFS_D0):  rd_val = d0;
      ADDR_W'(OFS_D1):  rd_val = d1;
      ADDR_W'(OFS_BLK): rd_val = '0;
      default:          mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      blk_sel_q <= 1'b0;
    end else if (rd_en) begin
      reg_q     <= rd_val;
      blk_sel_q <= (addr == ADDR_W'(OFS_BLK));
    end
  end

  assign rdata = blk_sel_q ? blk_q : reg_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rdata == '0)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !blk_sel_q) |=> $stable(rdata)); // R2

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned BLK_DEPTH = 32,
  localparam int unsigned IDX_W    = $clog2(BLK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              seq_start,
  output logic [2:0]        seq_prot,
  output logic [BYTE_W-1:0] seq_cmd,
  output logic [6:0]        seq_dev,
  output logic              seq_rnw,
  output logic [BYTE_W-1:0] seq_data0,
  output logic [BYTE_W-1:0] seq_data1,
  input  logic              seq_done,
  input  logic              seq_err,
  input  logic              seq_rsp_we,
  input  logic [BYTE_W-1:0] seq_rsp_data0,
  input  logic [BYTE_W-1:0] seq_rsp_data1,
  input  logic [IDX_W-1:0]  seq_blk_idx,
  output logic [BYTE_W-1:0] seq_blk_rdata
);

  logic [BYTE_W-1:0] ctl_q, cmd_q, adr_q, d0_q, d1_q, sts;
  logic [BYTE_W-1:0] blk_q;
  logic              start_q;
  logic              busy;

  // Address decode
  logic wr_sts, wr_ctl, wr_cmd, wr_adr, wr_d0, wr_d1, wr_blk;
  logic rd_ctl, rd_blk;

  assign wr_sts = host_wr && (host_addr == ADDR_W'(OFS_STS));
  assign wr_ctl = host_wr && (host_addr == ADDR_W'(OFS_CTL));
  assign wr_cmd = host_wr && (host_addr == ADDR_W'(OFS_CMD));
  assign wr_adr = host_wr && (host_addr == ADDR_W'(OFS_ADR));
  assign wr_d0  = host_wr && (host_addr == ADDR_W'(OFS_D0));
  assign wr_d1  = host_wr && (host_addr == ADDR_W'(OFS_D1));
  assign wr_blk = host_wr && (host_addr == ADDR_W'(OFS_BLK));
  assign rd_ctl = host_rd && (host_addr == ADDR_W'(OFS_CTL));
  assign rd_blk = host_rd && (host_addr == ADDR_W'(OFS_BLK));

  // Launch logic
  logic ctl_take, go, launch, bad_prot;

  assign busy     = sts[ST_BUSY];
  assign ctl_take = wr_ctl && !busy;
  assign go       = ctl_take && host_wdata[CTL_GO_BIT];
  assign launch   = go && prot_supported(host_wdata[4:2]);
  assign bad_prot = go && !prot_supported(host_wdata[4:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      cmd_q   <= '0;
      adr_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= launch;
      if (ctl_take) begin
        ctl_q             <= host_wdata;
        ctl_q[CTL_GO_BIT] <= 1'b0;
      end
      if (wr_cmd) cmd_q <= host_wdata;
      if (wr_adr) adr_q <= host_wdata;
      if (seq_rsp_we) begin
        d0_q <= seq_rsp_data0;
        d1_q <= seq_rsp_data1;
      end else begin
        if (wr_d0) d0_q <= host_wdata;
        if (wr_d1) d1_q <= host_wdata;
      end
    end
  end

  smb_status u_status (
    .clk      (clk),
    .rst      (rst),
    .clr      (wr_sts),
    .launch   (launch),
    .bad_prot (bad_prot),
    .done_i   (seq_done),
    .err_i    (seq_err),
    .status   (sts)
  );

  smb_blkbuf #(
    .DEPTH (BLK_DEPTH),
    .DW    (BYTE_W)
  ) u_blkbuf (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (wr_blk),
    .host_rd    (rd_blk),
    .idx_clr    (wr_sts || rd_ctl),
    .host_wdata (host_wdata),
    .host_q     (blk_q),
    .seq_idx    (seq_blk_idx),
    .seq_q      (seq_blk_rdata)
  );

  smb_rd_port #(
    .ADDR_W (ADDR_W)
  ) u_rd_port (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (host_rd),
    .addr   (host_addr),
    .sts    (sts),
    .ctl    (ctl_q),
    .cmd    (cmd_q),
    .adr    (adr_q),
    .d0     (d0_q),
    .d1     (d1_q),
    .blk_q  (blk_q),
    .rdata  (host_rdata)
  );

  assign seq_start = start_q;
  assign seq_prot  = ctl_q[4:2];
  assign seq_cmd   = cmd_q;
  assign seq_dev   = adr_q[7:1];
  assign seq_rnw   = adr_q[0];
  assign seq_data0 = d0_q;
  assign seq_data1 = d1_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> busy); // R5
  AST_START_PROT_OK: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> prot_supported(seq_prot)); // R6
  AST_CTL_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && busy) |=> ($stable(ctl_q) && !seq_start)); // R7

endmodule

// File: tb/smb_host_regs_tb_top.sv
module smb_host_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DEPTH      = 32;
  localparam int IW         = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_wr = 1'b0, host_rd = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic              seq_start;
  logic [2:0]        seq_prot;
  logic [7:0]        seq_cmd, seq_data0, seq_data1, seq_blk_rdata;
  logic [6:0]        seq_dev;
  logic              seq_rnw;
  logic              seq_done = 1'b0, seq_err = 1'b0, seq_rsp_we = 1'b0;
  logic [7:0]        seq_rsp_data0 = '0, seq_rsp_data1 = '0;
  logic [IW-1:0]     seq_blk_idx = '0;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;
  logic       saw_start;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_host_regs #(.ADDR_W(ADDR_W), .BLK_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .seq_start(seq_start), .seq_prot(seq_prot), .seq_cmd(seq_cmd),
    .seq_dev(seq_dev), .seq_rnw(seq_rnw), .seq_data0(seq_data0),
    .seq_data1(seq_data1), .seq_done(seq_done), .seq_err(seq_err),
    .seq_rsp_we(seq_rsp_we), .seq_rsp_data0(seq_rsp_data0),
    .seq_rsp_data1(seq_rsp_data1), .seq_blk_idx(seq_blk_idx),
    .seq_blk_rdata(seq_blk_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One-cycle write; saw_start holds seq_start in the cycle after the write
  task automatic wr(input int a, input int d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = ADDR_W'(a); host_wdata = 8'(d);
    @(negedge clk);
    host_wr = 1'b0;
    saw_start = seq_start;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = ADDR_W'(a);
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic pulse_done(input bit fail);
    @(negedge clk);
    if (fail) seq_err = 1'b1; else seq_done = 1'b1;
    @(negedge clk);
    seq_err = 1'b0; seq_done = 1'b0;
  endtask

  function automatic int blk_pat(input int i, input int salt);
    return (i * 37 + salt) & 8'hFF;
  endfunction

  function automatic bit is_mapped(input int a);
    return (a == 0) || (a >= 2 && a <= 7);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state across the window (block port left untouched)
    check("R1 start", int'(seq_start), 0);
    for (int a = 0; a < 64; a++) begin
      if (a == 7) continue;
      rd(a, rv);
      check("R1 reset read", rv, 0);
    end

    // R2 / R12: plain registers and sequencer view
    wr(3, 8'hA5); wr(4, 8'h9B); wr(5, 8'h3C); wr(6, 8'hD2);
    rd(3, rv); check("R2 cmd", rv, 8'hA5);
    rd(4, rv); check("R2 adr", rv, 8'h9B);
    rd(5, rv); check("R2 d0", rv, 8'h3C);
    rd(6, rv); check("R2 d1", rv, 8'hD2);
    @(negedge clk);
    check("R2 hold", host_rdata, 8'hD2);
    check("R12 cmd", seq_cmd, 8'hA5);
    check("R12 dev", seq_dev, 8'h9B >> 1);
    check("R12 rnw", seq_rnw, 1);
    check("R12 d0", seq_data0, 8'h3C);
    check("R12 d1", seq_data1, 8'hD2);

    // R3: writes to unmapped offsets are ignored, reads give 0
    for (int a = 1; a < 64; a++) if (!is_mapped(a)) wr(a, 8'hFF);
    for (int a = 1; a < 64; a++) if (!is_mapped(a)) begin
      rd(a, rv); check("R3 unmapped", rv, 0);
    end
    rd(3, rv); check("R3 cmd intact", rv, 8'hA5);
    rd(6, rv); check("R3 d1 intact", rv, 8'hD2);
    rd(0, rv); check("R3 sts intact", rv, 0);

    // R4: control store and masked readback, no launch without bit 6
    for (int v = 0; v < 256; v++) begin
      if (v[6]) continue;
      wr(2, v);
      check("R4 no start", int'(saw_start), 0);
      rd(2, rv);
      check("R4 ctl read", rv, v & 8'h1F);
    end

    // R5 / R6 / R8: sweep every protocol code with the start bit
    for (int p = 0; p < 8; p++) begin
      bit ok;
      ok = (p <= 3) || (p == 5);
      wr(2, 8'h40 | (p << 2));
      check(ok ? "R5 start" : "R6 no start", int'(saw_start), ok ? 1 : 0);
      @(negedge clk);
      check("R5 single pulse", int'(seq_start), 0);
      check("R12 prot", int'(seq_prot), p);
      rd(0, rv);
      check(ok ? "R5 busy" : "R6 err flag", rv, ok ? 8'h01 : 8'h04);
      if (ok) begin
        pulse_done(1'b0);
        rd(0, rv); check("R8 done", rv, 8'h02);
        repeat (3) @(negedge clk);
        rd(0, rv); check("R8 done sticky", rv, 8'h02);
      end
      wr(0, 8'h00);
      rd(0, rv); check("R9 clear", rv, 0);
    end

    // R7: control writes during busy are ignored; R8 error end
    wr(2, 8'h44);
    check("R5 start", int'(saw_start), 1);
    wr(2, 8'h5B);
    check("R7 no restart", int'(saw_start), 0);
    rd(2, rv); check("R7 ctl unchanged", rv, 8'h04);
    pulse_done(1'b1);
    rd(0, rv); check("R8 err", rv, 8'h04);
    wr(0, 8'hFF);
    rd(0, rv); check("R9 clear any value", rv, 0);

    // R12: response load of data bytes
    @(negedge clk);
    seq_rsp_we = 1'b1; seq_rsp_data0 = 8'h71; seq_rsp_data1 = 8'hE8;
    @(negedge clk);
    seq_rsp_we = 1'b0;
    rd(5, rv); check("R12 rsp d0", rv, 8'h71);
    rd(6, rv); check("R12 rsp d1", rv, 8'hE8);

    // R10: fill whole buffer, read back, read past the end
    wr(0, 0);
    for (int i = 0; i < DEPTH; i++) wr(7, blk_pat(i, 11));
    rd(2, rv);
    for (int i = 0; i < DEPTH; i++) begin
      rd(7, rv); check("R10 blk read", rv, blk_pat(i, 11));
    end
    rd(7, rv); check("R10 wrap read", rv, blk_pat(0, 11));
    // 33rd write lands on entry 0
    wr(0, 0);
    for (int i = 0; i < DEPTH; i++) wr(7, blk_pat(i, 11));
    wr(7, 8'h5E);
    rd(2, rv);
    rd(7, rv); check("R10 wrap write", rv, 8'h5E);
    rd(7, rv); check("R10 entry1", rv, blk_pat(1, 11));

    // R13: sequencer read port
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      seq_blk_idx = IW'(i);
      @(negedge clk);
      check("R13 seq read", seq_blk_rdata, (i == 0) ? 8'h5E : blk_pat(i, 11));
    end

    // R11: control read resets the index
    wr(0, 0);
    wr(7, 8'hC1); wr(7, 8'hC2); wr(7, 8'hC3);
    rd(2, rv);
    rd(7, rv); check("R11 idx reset", rv, 8'hC1);

    // R9: status write resets the index
    rd(7, rv);
    wr(0, 8'h80);
    rd(7, rv); check("R9 idx reset", rv, 8'hC1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule